// File: doc/BRIEF.md
# Six-Channel Linear Volume Attenuator

This block holds one gain code per audio channel and scales each channel's signed 24-bit sample stream by that code. Gain codes arrive as 16-bit configuration words from a control port that has already been deserialised. Each word is presented in parallel with a one-cycle write strobe. The word carries a register address, two reserved bits and a 10-bit gain code. A word is accepted only if its address selects one of the six channels and its reserved bits are zero. Any other word is dropped, and no state changes.

Each channel has its own sample strobe. When a channel's strobe is seen, the sample is multiplied by (code + 1) / 1024. The result is truncated toward minus infinity and registered. It is then presented one cycle later together with a valid pulse. The output holds between strobes. A code change therefore only ever applies from the next sample of that channel, never partway through a sample.

Top module: `chan_gain_bank`

## Requirements
- R1: In a configuration word, bits 15..12 are the address, bits 11..10 are reserved and bits 9..0 are the gain code. Address 2 selects channel 1 (index 0) and each higher address selects the next channel, up to address 7 for channel 6 (index 5).
- R2: A configuration word with either reserved bit set is discarded, and no gain code changes.
- R3: A configuration word whose address is below 2 or above 7 is discarded, and no gain code changes.
- R4: A synchronous active-low reset sets every gain code to 1023. It also clears every output sample to zero and every output valid bit to zero.
- R5: For a channel, out = floor(sample × (code + 1) / 1024), with the sample in signed two's complement. Rounding is toward minus infinity, so a negative result rounds down.
- R6: With code 1023 the output equals the input sample exactly.
- R7: A write changes only the addressed channel's code. Samples on every other channel keep being scaled by their own codes.
- R8: The output for a channel is registered. It appears with a one-cycle valid pulse on the clock edge after the edge that samples the channel's strobe. Without a strobe, the output holds its value and the valid bit stays low.
- R9: A strobe sampled on the same clock edge as a write to that channel is scaled with the code held before that edge. The new code applies from the next strobe.
- R10: With code 0 the output is floor(sample / 1024).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe marking a valid configuration word |
| cfg_word | input | 16 | Configuration word: address, reserved bits, gain code |
| smp_vld | input | 6 | Per-channel sample strobe; bit i belongs to channel index i |
| smp_in | input | 144 | Input samples; channel i in bits [24*i+23 : 24*i] |
| out_vld | output | 6 | Per-channel output valid pulse |
| smp_out | output | 144 | Scaled samples, same packing as smp_in |

## Verification
The assertions assume that `cfg_wr` and `smp_vld` are single-cycle pulses, sampled cleanly at the rising edge. They also assume that `smp_in` is stable whenever a channel's strobe is high. The bench drives every input on the falling edge and holds it for exactly one period, so each strobe is seen at exactly one rising edge. It reads the outputs on the following falling edge. The stimulus mixes legal writes with words that carry reserved bits or out-of-range addresses, and it places a write on the same edge as a strobe to exercise R9.

// File: rtl/chan_gain_pkg.sv
// Package chan_gain_pkg
// Shared sizes and field layout for the channel gain bank. The word layout
// constants are the only place the field positions are defined.
package chan_gain_pkg;
    localparam int NUM_CH    = 6;   // channels
    localparam int DATA_W    = 24;  // sample width
    localparam int CODE_W    = 10;  // gain code width
    localparam int WORD_W    = 16;  // configuration word width
    localparam int ADDR_W    = 4;   // address field width
    localparam int BASE_ADDR = 2;   // address of channel index 0
    localparam int RSV_W     = WORD_W - ADDR_W - CODE_W;

    // Decoded view of a configuration word.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [RSV_W-1:0]  rsv;
        logic [CODE_W-1:0] code;
    } cfg_word_t;
endpackage

// File: rtl/cfg_word_decode.sv
// Module cfg_word_decode
// Splits a configuration word into its fields and raises at most one
// per-channel write enable. A word with nonzero reserved bits or an address
// outside the channel window raises none. Purely combinational.
// Assumes: cfg_wr is a single-cycle strobe qualified by the caller's clock.
module cfg_word_decode
    import chan_gain_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int C_W   = CODE_W,
    parameter int W_W   = WORD_W,
    parameter int A_W   = ADDR_W,
    parameter int BASE  = BASE_ADDR
) (
    input  logic           cfg_wr,
    input  logic [W_W-1:0] cfg_word,
    output logic [N_CH-1:0] wen,
    output logic [C_W-1:0]  wdata
);
    localparam int R_W = W_W - A_W - C_W;

    logic [A_W-1:0] addr;
    logic [R_W-1:0] rsv;
    logic           legal;

    // Field extraction from the packed word.
    always_comb begin
        addr  = cfg_word[W_W-1 -: A_W];
        rsv   = cfg_word[C_W +: R_W];
        wdata = cfg_word[C_W-1:0];
    end

    // Word is legal only with clear reserved bits and an in-window address.
    always_comb begin
        legal = cfg_wr && (rsv == '0)
                && (int'(addr) >= BASE) && (int'(addr) < BASE + N_CH);
    end

    // One enable per channel, matched against that channel's own address.
    for (genvar i = 0; i < N_CH; i++) begin : g_en
        always_comb begin
            wen[i] = legal && (addr == A_W'(BASE + i));
        end
    end
endmodule

// File: rtl/gain_code_reg.sv
// Module gain_code_reg
// Holds one channel's gain code. Loads on its write enable, otherwise holds.
// Resets to all ones (unity gain).
// Assumes: wen comes from the decoder and is one cycle wide.
module gain_code_reg #(
    parameter int C_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wen,
    input  logic [C_W-1:0] wdata,
    output logic [C_W-1:0] code
);
    // Code storage with synchronous reset to unity.
    always_ff @(posedge clk) begin
        if (!rst_n)   code <= '1;
        else if (wen) code <= wdata;
    end

    // R7: without a write the code does not move.
    assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wen |=> $stable(code));

    // R9: a write lands on the next cycle's code.
    assert_code_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wen |=> code == $past(wdata));
endmodule

// File: rtl/gain_stage.sv
// Module gain_stage
// Scales one channel's signed sample by (code+1)/2^C_W with floor rounding.
// Registers the result together with a valid pulse.
// Assumes: sample is stable while vld is high; code is the value held
// before the current edge.
module gain_stage #(
    parameter int D_W = 24,
    parameter int C_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vld,
    input  logic [C_W-1:0]        code,
    input  logic signed [D_W-1:0] sample,
    output logic signed [D_W-1:0] out,
    output logic                  out_vld
);
    localparam int G_W = C_W + 2;          // signed gain width, holds 2^C_W
    localparam int P_W = D_W + G_W;        // full product width

    logic signed [G_W-1:0] gain;
    logic signed [P_W-1:0] prod;
    logic signed [D_W-1:0] scaled;

    // Gain is code+1 as a positive signed value.
    always_comb begin
        gain = G_W'(code) + G_W'(1);
    end

    // Full-precision product, then arithmetic shift gives the floor.
    always_comb begin
        prod   = sample * gain;
        scaled = D_W'(prod >>> C_W);
    end

    // Output register: load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out     <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= vld;
            if (vld) out <= scaled;
        end
    end

    // R8: no strobe keeps the output and suppresses the valid pulse.
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(out) && !out_vld);

    // R6: full-scale code passes the sample through unchanged.
    assert_unity_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && code == '1) |=> (out == $past(sample)) && out_vld);
endmodule

// File: rtl/chan_gain_bank.sv
// Module chan_gain_bank
// Top level: one decoder feeds per-channel gain code registers, and each
// register drives that channel's scaling stage.
// Assumes: cfg_wr and smp_vld bits are single-cycle strobes.
module chan_gain_bank
    import chan_gain_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int D_W  = DATA_W,
    parameter int C_W  = CODE_W,
    parameter int W_W  = WORD_W,
    parameter int A_W  = ADDR_W,
    parameter int BASE = BASE_ADDR
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [W_W-1:0]      cfg_word,
    input  logic [N_CH-1:0]     smp_vld,
    input  logic [N_CH*D_W-1:0] smp_in,
    output logic [N_CH-1:0]     out_vld,
    output logic [N_CH*D_W-1:0] smp_out
);
    localparam int R_W = W_W - A_W - C_W;

    logic [N_CH-1:0] wen;
    logic [C_W-1:0]  wdata;

    // Word decode into per-channel enables.
    cfg_word_decode #(
        .N_CH(N_CH), .C_W(C_W), .W_W(W_W), .A_W(A_W), .BASE(BASE)
    ) dec_i (
        .cfg_wr  (cfg_wr),
        .cfg_word(cfg_word),
        .wen     (wen),
        .wdata   (wdata)
    );

    // R1: never more than one channel written per word.
    assert_onehot_wen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wen));

    // R2: reserved bits set means no channel is written.
    assert_rsv_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_word[C_W +: R_W] != '0) |-> wen == '0);

    // R3: out-of-window address means no channel is written.
    assert_addr_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (int'(cfg_word[W_W-1 -: A_W]) < BASE
                    || int'(cfg_word[W_W-1 -: A_W]) >= BASE + N_CH))
        |-> wen == '0);

    // One code register and one scaling stage per channel.
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [C_W-1:0] code;

        gain_code_reg #(.C_W(C_W)) reg_i (
            .clk  (clk),
            .rst_n(rst_n),
            .wen  (wen[i]),
            .wdata(wdata),
            .code (code)
        );

        gain_stage #(.D_W(D_W), .C_W(C_W)) stage_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (smp_vld[i]),
            .code   (code),
            .sample (smp_in[i*D_W +: D_W]),
            .out    (smp_out[i*D_W +: D_W]),
            .out_vld(out_vld[i])
        );
    end
endmodule

// File: tb/chan_gain_bank_tb_top.sv
`timescale 1ns/1ps
// Directed bench for chan_gain_bank. Inputs change on falling edges and
// outputs are read on the falling edge after the capturing rising edge.
module chan_gain_bank_tb_top;
    localparam int NCH = 6;
    localparam int DW  = 24;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_wr;
    logic [15:0]       cfg_word;
    logic [NCH-1:0]    smp_vld;
    logic [NCH*DW-1:0] smp_in;
    logic [NCH-1:0]    out_vld;
    logic [NCH*DW-1:0] smp_out;

    int n_chk  = 0;
    int n_fail = 0;
    int model_code [NCH];
    logic [DW-1:0] model_out [NCH];

    always #4 clk = ~clk;   // 125 MHz

    chan_gain_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .smp_vld(smp_vld), .smp_in(smp_in),
        .out_vld(out_vld), .smp_out(smp_out)
    );

    function automatic logic [DW-1:0] expect_scale(logic signed [DW-1:0] s, int c);
        longint p = longint'(s) * longint'(c + 1);
        return DW'(p >>> 10);
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bench-side record of a write, from the word layout in R1..R3.
    task automatic model_write(logic [15:0] w);
        int a = int'(w[15:12]);
        if (w[11:10] == 2'b00 && a >= 2 && a <= 7) model_code[a-2] = int'(w[9:0]);
    endtask

    task automatic do_write(logic [15:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_word = w;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_word = '0;
        model_write(w);
    endtask

    // Strobe channels in mask; check every channel's output and valid bit.
    task automatic do_strobe(string req, logic [NCH-1:0] mask,
                             logic signed [DW-1:0] v [NCH], logic [15:0] w, bit wr);
        @(negedge clk);
        for (int i = 0; i < NCH; i++) smp_in[i*DW +: DW] = v[i];
        smp_vld = mask;
        cfg_wr = wr; cfg_word = w;
        @(negedge clk);
        smp_vld = '0; cfg_wr = 1'b0; cfg_word = '0;
        for (int i = 0; i < NCH; i++)
            if (mask[i]) model_out[i] = expect_scale(v[i], model_code[i]);
        if (wr) model_write(w);
        check({req, " valid"}, DW'(out_vld), DW'(mask));
        for (int i = 0; i < NCH; i++)
            check(req, smp_out[i*DW +: DW], model_out[i]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_word = '0; smp_vld = '0; smp_in = '0;
        for (int i = 0; i < NCH; i++) begin model_code[i] = 1023; model_out[i] = '0; end
        repeat (3) @(negedge clk);
        check("R4 reset valid", DW'(out_vld), '0);
        for (int i = 0; i < NCH; i++) check("R4 reset out", smp_out[i*DW +: DW], '0);
        rst_n = 1'b1;
    endtask

    task automatic t_unity();
        logic signed [DW-1:0] v [NCH] = '{24'sh7FFFFF, -24'sd8388608, 24'sd1,
                                         -24'sd1, 24'sh123456, -24'sd99999};
        do_strobe("R6 R4 unity after reset", 6'h3F, v, '0, 0);
    endtask

    task automatic t_single_channel();
        logic signed [DW-1:0] v [NCH] = '{24'sd4000, 24'sd4000, 24'sd4000,
                                         24'sd4000, 24'sd4000, 24'sd4000};
        do_write({4'd4, 2'b00, 10'd511});         // channel index 2
        do_strobe("R1 R7 half gain on one channel", 6'h3F, v, '0, 0);
        do_write({4'd2, 2'b00, 10'd255});         // channel index 0
        do_write({4'd7, 2'b00, 10'd767});         // channel index 5
        do_strobe("R1 R5 mixed codes", 6'h3F, v, '0, 0);
    endtask

    task automatic t_negative_floor();
        logic signed [DW-1:0] v [NCH] = '{-24'sd3, -24'sd1025, -24'sd4000,
                                         -24'sd7, 24'sd1023, -24'sd8388608};
        do_write({4'd5, 2'b00, 10'd100});
        do_strobe("R5 floor on negatives", 6'h3F, v, '0, 0);
    endtask

    task automatic t_code_zero();
        logic signed [DW-1:0] v [NCH] = '{24'sd1023, 24'sd2048, -24'sd1,
                                         24'sd5000, 24'sh7FFFFF, -24'sd1025};
        for (int i = 0; i < NCH; i++) do_write({4'(i + 2), 2'b00, 10'd0});
        do_strobe("R10 code zero", 6'h3F, v, '0, 0);
    endtask

    task automatic t_reserved_drop();
        logic signed [DW-1:0] v [NCH] = '{24'sd65536, 24'sd65536, 24'sd65536,
                                         24'sd65536, 24'sd65536, 24'sd65536};
        do_write({4'd3, 2'b01, 10'd1023});
        do_write({4'd4, 2'b10, 10'd1023});
        do_write({4'd6, 2'b11, 10'd512});
        do_strobe("R2 reserved words dropped", 6'h3F, v, '0, 0);
    endtask

    task automatic t_addr_drop();
        logic signed [DW-1:0] v [NCH] = '{-24'sd70000, 24'sd70000, -24'sd70000,
                                         24'sd70000, -24'sd70000, 24'sd70000};
        do_write({4'd0, 2'b00, 10'd1023});
        do_write({4'd1, 2'b00, 10'd1023});
        do_write({4'd8, 2'b00, 10'd1023});
        do_write({4'd15, 2'b00, 10'd1023});
        do_strobe("R3 out-of-window words dropped", 6'h3F, v, '0, 0);
    endtask

    task automatic t_same_edge();
        logic signed [DW-1:0] v [NCH] = '{24'sd10240, 24'sd10240, 24'sd10240,
                                         24'sd10240, 24'sd10240, 24'sd10240};
        do_strobe("R9 strobe with write uses old code", 6'h02, v,
                  {4'd3, 2'b00, 10'd1023}, 1);
        do_strobe("R9 new code on next strobe", 6'h02, v, '0, 0);
    endtask

    task automatic t_hold();
        logic signed [DW-1:0] v [NCH] = '{24'sd1, 24'sd2, 24'sd3,
                                         24'sd4, 24'sd5, 24'sd6};
        do_strobe("R8 partial strobe", 6'h15, v, '0, 0);
        @(negedge clk);
        smp_in = '1;
        do_write({4'd2, 2'b00, 10'd1});
        @(negedge clk);
        check("R8 no strobe valid low", DW'(out_vld), '0);
        for (int i = 0; i < NCH; i++) check("R8 hold", smp_out[i*DW +: DW], model_out[i]);
    endtask

    initial begin
        #(8ns * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_unity();
        t_single_channel();
        t_negative_floor();
        t_code_zero();
        t_reserved_drop();
        t_addr_drop();
        t_same_edge();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule